// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a clause 22 management-bus master for talking to external PHYs. Software controls it through a single 32-bit word. Writing that word with the request bit set launches one management frame on the MDC clock and the MDIO data pin. Reading the word back returns three things: the busy state, the command fields that were last accepted, and, once a read has finished, the 16-bit value that the PHY returned.

A transaction lasts 65 MDC periods:

- 64 frame bits.
- One idle period, during which the pin is released before the engine reports completion.

MDC is derived from the system clock by a parameterised half-period count. With the default of 50 system cycles per half period, a 250 MHz system clock gives an MDC of 2.5 MHz.

Software polls the request bit and must wait for it to clear before issuing the next command. Any write that arrives while a transaction is running is discarded.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads as all zeros, MDC is low and the MDIO output enable is low.
- R2: While idle, a write with bit 31 set starts a transaction. From the next cycle, bit 31 reads 1, bit 30 reads back the operation (1 read, 0 write), bits 25:21 the PHY address and bits 20:16 the register number.
- R3: While idle, a write with bit 31 clear has no effect: the word keeps its previous value and no frame starts.
- R4: While bit 31 reads 1, every write is discarded, and neither the read-back word nor the frame being sent changes.
- R5: While busy, MDC is low for the first MDC_HALF_DIV cycles after acceptance and then toggles every MDC_HALF_DIV cycles. While idle it stays low.
- R6: The frame is sent MSB first, one bit per MDC period, each bit presented while MDC is low. The bits are, in order:
  - 32 ones;
  - the start pattern 01;
  - the opcode, 10 for a read or 01 for a write;
  - the 5-bit PHY address;
  - the 5-bit register number.
- R7: A write continues with the turnaround 10 and then bits 15:0 of the command word, MSB first, all driven.
- R8: The output enable is low during a read's turnaround and 16 data periods, and during the final idle period of every transaction.
- R9: A read samples the MDIO input on each MDC rising edge of the 16 data periods, MSB first. At completion it places the result in bits 15:0.
- R10: Bit 31 clears on the MDC falling edge that ends the period after the last data bit, which is 130*MDC_HALF_DIV cycles after acceptance.
- R11: While busy, bits 15:0 show the low half of the accepted command word. Read data replaces them only in the cycle where bit 31 clears. After a write, they keep the data that was written.
- R12: Bits 29:26 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Busy flag, accepted command and returned data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_in | input | 1 | Management data from the pad |

## Verification
Assertions run on every cycle and check the following:

- The pad is quiet and MDC is low whenever the engine is idle.
- MDC rising and falling strobes never coincide.
- The frame position advances only on an MDC falling edge.
- The capture register moves only on a rising edge during a read.
- The busy flag drops only at the falling edge that ends the idle tail.
- A discarded write leaves the held command untouched.

Only the bench scenarios can show the following:

- The exact frame content bit by bit.
- The read value assembled from the PHY's reply.
- The 130-half-period latency.
- The point at which read data first becomes visible.

The bench shows these by comparing every cycle against a behavioural model for writes, for reads and for commands that are rejected.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_IDX     = PRE_BITS + 4 + PHY_W + REG_W;
  localparam int DATA_IDX   = TA_IDX + 2;
  localparam int TAIL_IDX   = FRAME_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);

  // field positions inside the 32-bit command word
  localparam int REQ_BIT = 31;
  localparam int RD_BIT  = 30;
  localparam int PHY_LSB = 21;
  localparam int REG_LSB = 16;

  typedef struct packed {
    logic              rd;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regn;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] dat;
    op  = c.rd ? 2'b10 : 2'b01;
    ta  = c.rd ? 2'b11 : 2'b10;
    dat = c.rd ? {DATA_W{1'b0}} : c.data;
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, ta, dat};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap & ~mdc_q;
  assign fall_o = wrap &  mdc_q;

  // R5
  mdc_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));

  // R5
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] cap_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);

  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(DATA_IDX);
  localparam logic [IDX_W-1:0] TAIL_POS = IDX_W'(TAIL_IDX);

  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [DATA_W-1:0]     cap_q, cap_d;
  logic                  done_d;
  logic                  in_data;

  assign in_data = (idx_q >= DATA_POS) && (idx_q < TAIL_POS);

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    idx_d   = idx_q;
    frame_d = frame_q;
    cap_d   = cap_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        rd_d    = cmd_i.rd;
        idx_d   = '0;
        frame_d = build_frame(cmd_i);
      end
    end else begin
      if (rise_i && rd_q && in_data) begin
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end
      if (fall_i) begin
        if (idx_q == TAIL_POS) begin
          busy_d = 1'b0;
          idx_d  = '0;
          done_d = 1'b1;
        end else begin
          idx_d   = idx_q + 1'b1;
          frame_d = {frame_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
      cap_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      idx_q   <= idx_d;
      frame_q <= frame_d;
      cap_q   <= cap_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_d;
  assign cap_o     = cap_q;
  assign mdio_oe_o = busy_q && (idx_q < TAIL_POS) && !(rd_q && (idx_q >= TA_POS));
  assign mdio_o    = busy_q && frame_q[FRAME_BITS-1];

  // R10
  busy_end_on_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(fall_i) && ($past(idx_q) == TAIL_POS)));

  // R6
  advance_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(idx_q)) |-> $past(fall_i));

  // R9
  capture_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> ($past(rise_i) && $past(rd_q)));

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] cap_i,
  output logic              start_o,
  output mdio_cmd_t         req_o,
  output logic [31:0]       rdata_o
);

  mdio_cmd_t cmd_q, cmd_d;
  mdio_cmd_t req;

  assign req.rd   = wdata_i[RD_BIT];
  assign req.phy  = wdata_i[PHY_LSB +: PHY_W];
  assign req.regn = wdata_i[REG_LSB +: REG_W];
  assign req.data = wdata_i[DATA_W-1:0];

  assign start_o = wr_i && wdata_i[REQ_BIT] && !busy_i;
  assign req_o   = req;

  always_comb begin
    cmd_d = cmd_q;
    if (start_o) begin
      cmd_d = req;
    end else if (done_i && cmd_q.rd) begin
      cmd_d.data = cap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  assign rdata_o = {busy_i, cmd_q.rd, 4'b0000, cmd_q.phy, cmd_q.regn, cmd_q.data};

  // R4
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && wr_i && !done_i) |=> $stable(cmd_q));

  // R3
  idle_noreq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && wr_i && !wdata_i[REQ_BIT]) |=> ($stable(cmd_q) && !busy_i));

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int MDC_HALF_DIV = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);

  logic              busy;
  logic              done;
  logic              start;
  logic              rise;
  logic              fall;
  logic [DATA_W-1:0] cap;
  mdio_cmd_t         req;

  mdio_cmd_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cmd_wr),
    .wdata_i (cmd_wdata),
    .busy_i  (busy),
    .done_i  (done),
    .cap_i   (cap),
    .start_o (start),
    .req_o   (req),
    .rdata_o (cmd_rdata)
  );

  mdio_mdc_gen #(
    .HALF_DIV (MDC_HALF_DIV)
  ) u_mdc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .cmd_i     (req),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_in),
    .busy_o    (busy),
    .done_o    (done),
    .cap_o     (cap),
    .mdio_o    (mdio_out),
    .mdio_oe_o (mdio_oe)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[REQ_BIT] |-> (!mdio_oe && !mdc));

  // R12
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[29:26] == 4'b0000);

endmodule

// File: tb/test_mdio_cmd_engine.sv
`timescale 1ns/1ps
module test_mdio_cmd_engine;

  localparam int H         = 3;
  localparam int FRAME_CYC = 130 * H;
  localparam int WD_LIMIT  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        mdio_in = 1'b1;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_out, mdio_oe;

  always #2 clk = ~clk;

  mdio_cmd_engine #(.MDC_HALF_DIV(H)) i_mdio_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit over    = 0;

  // behavioural reference state
  bit          m_busy = 0;
  int          m_k = 0;
  bit          m_rd = 0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [15:0] m_data = '0, m_cap = '0;
  logic [63:0] m_frame = '0;
  logic [15:0] reply = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!over) begin
      over = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic logic [63:0] ref_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                                            input logic [15:0] d);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b11 : 2'b10), (rd ? 16'h0000 : d)};
    return f;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_rd = 0; m_phy = '0; m_reg = '0; m_data = '0; m_cap = '0;
    end else if (m_busy) begin
      m_k++;
      if ((m_k % (2 * H)) == H) begin
        if (m_rd && (m_k / (2 * H)) >= 48 && (m_k / (2 * H)) < 64)
          m_cap = {m_cap[14:0], mdio_in};
      end
      if (m_k == FRAME_CYC) begin
        m_busy = 0;
        if (m_rd) m_data = m_cap;
      end
    end else if (cmd_wr && cmd_wdata[31]) begin
      m_busy  = 1;
      m_k     = 0;
      m_rd    = cmd_wdata[30];
      m_phy   = cmd_wdata[25:21];
      m_reg   = cmd_wdata[20:16];
      m_data  = cmd_wdata[15:0];
      m_frame = ref_frame(m_rd, m_phy, m_reg, m_data);
    end
    if (cyc > WD_LIMIT && !over) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_LIMIT);
      report();
    end
  end

  // PHY side: reply bits during the data phase of a read
  always @(negedge clk) begin
    if (m_busy && m_rd && (m_k / (2 * H)) >= 48 && (m_k / (2 * H)) < 64)
      mdio_in <= reply[63 - (m_k / (2 * H))];
    else
      mdio_in <= 1'b1;
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !over) begin
      int   idx;
      logic e_mdc, e_oe;
      logic [31:0] e_rd;
      idx   = m_k / (2 * H);
      e_mdc = m_busy ? logic'((m_k / H) % 2) : 1'b0;
      e_oe  = m_busy && idx < 64 && !(m_rd && idx >= 46);
      e_rd  = {m_busy, m_rd, 4'b0000, m_phy, m_reg, m_data};
      chk(mdc === e_mdc, "R5 mdc", {31'd0, mdc}, {31'd0, e_mdc});
      chk(mdio_oe === e_oe, "R8 oe", {31'd0, mdio_oe}, {31'd0, e_oe});
      if (e_oe)
        chk(mdio_out === m_frame[63 - idx], (idx >= 46) ? "R7 data bit" : "R6 frame bit",
            {31'd0, mdio_out}, {31'd0, m_frame[63 - idx]});
      chk(cmd_rdata === e_rd, "R11 readback", cmd_rdata, e_rd);
    end
  end

  task automatic issue(input logic [31:0] w);
    cmd_wr    = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_wr    = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rdata[31] && n < 10000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_rdata === 32'h0, "R1 rdata", cmd_rdata, 32'h0);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 pins", {30'd0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: no request bit, nothing happens
    issue(32'h3FFF_FFFF);
    chk(cmd_rdata === 32'h0, "R3 no start", cmd_rdata, 32'h0);
    repeat (4) @(negedge clk);
    chk(mdio_oe === 1'b0, "R3 pad quiet", {31'd0, mdio_oe}, 32'h0);

    // write transaction, reserved bits set in the request
    issue({1'b1, 1'b0, 4'hF, 5'h11, 5'h04, 16'hA5C3});
    chk(cmd_rdata === {1'b1, 1'b0, 4'h0, 5'h11, 5'h04, 16'hA5C3}, "R2 accepted",
        cmd_rdata, {1'b1, 1'b0, 4'h0, 5'h11, 5'h04, 16'hA5C3});
    chk(cmd_rdata[29:26] === 4'h0, "R12 reserved", {28'd0, cmd_rdata[29:26]}, 32'h0);
    repeat (20) @(negedge clk);
    // R4: write while busy discarded
    issue(32'hC3E0_1234);
    chk(cmd_rdata === {1'b1, 1'b0, 4'h0, 5'h11, 5'h04, 16'hA5C3}, "R4 ignored",
        cmd_rdata, {1'b1, 1'b0, 4'h0, 5'h11, 5'h04, 16'hA5C3});
    wait_idle(n);
    chk(cmd_rdata === {1'b0, 1'b0, 4'h0, 5'h11, 5'h04, 16'hA5C3}, "R7 write done",
        cmd_rdata, {1'b0, 1'b0, 4'h0, 5'h11, 5'h04, 16'hA5C3});

    // read transaction
    reply = 16'h8001;
    issue({1'b1, 1'b1, 4'h0, 5'h1F, 5'h00, 16'h7777});
    chk(cmd_rdata[15:0] === 16'h7777, "R11 data hidden", {16'd0, cmd_rdata[15:0]}, 32'h7777);
    wait_idle(n);
    chk(n == FRAME_CYC, "R10 latency", n, FRAME_CYC);
    chk(cmd_rdata === {1'b0, 1'b1, 4'h0, 5'h1F, 5'h00, 16'h8001}, "R9 read value",
        cmd_rdata, {1'b0, 1'b1, 4'h0, 5'h1F, 5'h00, 16'h8001});

    // second read, different pattern
    reply = 16'h3C5A;
    issue({1'b1, 1'b1, 4'h0, 5'h00, 5'h1F, 16'h0000});
    repeat (200) @(negedge clk);
    chk(cmd_rdata[15:0] === 16'h0000, "R11 mid read", {16'd0, cmd_rdata[15:0]}, 32'h0);
    wait_idle(n);
    chk(cmd_rdata[15:0] === 16'h3C5A, "R9 read value 2", {16'd0, cmd_rdata[15:0]}, 32'h3C5A);

    // back-to-back write right after completion
    issue({1'b1, 1'b0, 4'h0, 5'h0A, 5'h15, 16'h0F0F});
    chk(cmd_rdata[31] === 1'b1, "R2 back-to-back", {31'd0, cmd_rdata[31]}, 32'h1);
    wait_idle(n);
    chk(n == FRAME_CYC, "R10 latency write", n, FRAME_CYC);
    chk(cmd_rdata === {1'b0, 1'b0, 4'h0, 5'h0A, 5'h15, 16'h0F0F}, "R7 write 2",
        cmd_rdata, {1'b0, 1'b0, 4'h0, 5'h0A, 5'h15, 16'h0F0F});

    repeat (5) @(negedge clk);
    report();
  end

endmodule